// File: doc/BRIEF.md
# Clock Manager Lock Supervisor

This block supervises an on-chip clock synthesizer by watching its status flags. It runs on the synthesizer's reference input clock, so it keeps working while the synthesized clock is absent. When automatic relock is enabled and the synthesizer is not locked, the block checks it, sends a reset pulse when the check fails, and waits a settling time before checking again. The block treats a stopped input clock as a fault. It also treats a stopped synthesized clock as a fault when the frequency-synthesis output is in use. Once lock is held, it keeps watching and starts a new recovery cycle if lock is lost or a fault appears.

Downstream logic receives a hold signal that stays high until the synthesizer is locked and fault-free. Software sees two records of past recovery: a sticky flag and a saturating count of automatic resets. Both clear only on the global reset or on a user reset. When automatic relock is disabled, the block only forwards the user reset to the synthesizer.

Top module: `lock_supervisor`

## Requirements
- R1: The three status inputs pass through two synchronizer stages and an output register. A change on `lock_raw` reaches `hold_rst` on the third rising edge after it is driven, and not before.
- R2: While `auto_en` is low, `synth_rst` equals `usr_rst` delayed by one cycle. No automatic reset is issued, and `relock_seen` and `retry_cnt` do not increase.
- R3: Each automatic reset on `synth_rst` is high for exactly one reference-clock cycle. After `auto_en` rises with lock absent, the first automatic pulse appears two cycles later.
- R4: After each automatic pulse, the block waits SETTLE_CYC cycles (default CYC_PER_US × WAIT_US, with CYC_PER_US = 25 for a 25 MHz reference) on one shared counter, then checks again. While lock stays low, consecutive pulses therefore start SETTLE_CYC + 2 cycles apart.
- R5: An asserted input-clock-stopped flag counts as a fault. It causes an automatic reset even when lock is high.
- R6: The synthesized-clock-stopped flag counts as a fault only while `fx_mode` is 1. With `fx_mode` at 0, the flag causes no reset and does not hold downstream logic.
- R7: `relock_seen` is set by the first automatic reset. It stays set, including across disable, until `rst_n` is asserted or `usr_rst` is asserted.
- R8: `retry_cnt` counts automatic resets since the last user reset or global reset, and stops at 2^RETRY_W − 1.
- R9: `hold_rst` is 1 out of reset. It is 0 only while the synchronized lock flag is 1, no fault is present and `usr_rst` is low.
- R10: `usr_rst` has priority over an automatic reset that falls in the same cycle. On the next cycle `synth_rst` and `hold_rst` are 1 and `relock_seen` and `retry_cnt` are cleared. When enabled, the next check follows SETTLE_CYC cycles after the user reset is released, so any following pulse appears SETTLE_CYC + 1 cycles after the user-reset pulse.
- R11: Once locked, a loss of lock causes an automatic reset on the third rising edge after the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Synthesizer reference input clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| auto_en | input | 1 | Enables automatic relock; 0 means only the user reset is forwarded |
| usr_rst | input | 1 | User reset request, active high |
| fx_mode | input | 1 | 1 when the frequency-synthesis output is used, so its stop flag is checked |
| lock_raw | input | 1 | Synthesizer lock flag, asynchronous |
| inclk_stop_raw | input | 1 | Input-clock-stopped flag, asynchronous |
| fxclk_stop_raw | input | 1 | Synthesized-clock-stopped flag, asynchronous |
| synth_rst | output | 1 | Reset to the synthesizer |
| hold_rst | output | 1 | Holds downstream logic in reset until lock is good |
| relock_seen | output | 1 | Sticky: an automatic reset has been issued |
| retry_cnt | output | RETRY_W | Saturating count of automatic resets |

## Verification
The coincidence that matters is a user reset in the same cycle as an automatic retry. The bench measures the retry period from observed pulses. It then raises the user reset exactly on the edge where the next retry would fire. The outcome is judged on one pulse rather than two, on cleared retry records, and on a fresh settling wait that starts from the release. A cycle model in the bench follows every output on every clock, so a late fault or an extra pulse shows up in the cycle it occurs.

// File: rtl/lsup_pkg.sv
package lsup_pkg;

    typedef enum logic [2:0] {
        SV_OFF    = 3'd0,
        SV_PULSE  = 3'd1,
        SV_SETTLE = 3'd2,
        SV_PROBE  = 3'd3,
        SV_WATCH  = 3'd4
    } sup_state_e;

    // synchronized status flags, bit order used by the synchronizer bus
    typedef struct packed {
        logic lock;
        logic in_stop;
        logic fx_stop;
    } stat_t;

    typedef struct packed {
        sup_state_e st;
        logic       pulse;
        logic       hold;
        logic       sticky;
    } ctl_t;

endpackage

// File: rtl/lsup_sync.sv
module lsup_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsup_health.sv
module lsup_health
    import lsup_pkg::*;
(
    input  stat_t stat_i,
    input  logic  fx_mode,
    output logic  fault_o,
    output logic  good_o
);
    always_comb begin
        fault_o = stat_i.in_stop | (fx_mode & stat_i.fx_stop);
        good_o  = stat_i.lock & ~fault_o;
    end
endmodule

// File: rtl/lsup_wait_timer.sv
module lsup_wait_timer #(
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = LOAD_VAL;
        else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/lsup_sat_count.sv
module lsup_sat_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                       cnt_d = '0;
        else if (inc && cnt_q != '1)   cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor
    import lsup_pkg::*;
#(
    parameter int CYC_PER_US  = 25,
    parameter int WAIT_US     = 4,
    parameter int SETTLE_CYC  = CYC_PER_US * WAIT_US,
    parameter int RETRY_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               auto_en,
    input  logic               usr_rst,
    input  logic               fx_mode,
    input  logic               lock_raw,
    input  logic               inclk_stop_raw,
    input  logic               fxclk_stop_raw,
    output logic               synth_rst,
    output logic               hold_rst,
    output logic               relock_seen,
    output logic [RETRY_W-1:0] retry_cnt
);
    localparam int STAT_W = $bits(stat_t);

    stat_t stat_s;
    logic  fault, good;
    logic  tmr_load, tmr_done;
    logic  rc_clr, rc_inc, retry;
    ctl_t  ctl_d, ctl_q;

    lsup_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .async_i ({lock_raw, inclk_stop_raw, fxclk_stop_raw}),
        .sync_o  (stat_s)
    );

    lsup_health u_health (
        .stat_i  (stat_s),
        .fx_mode (fx_mode),
        .fault_o (fault),
        .good_o  (good)
    );

    lsup_wait_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .load  (tmr_load),
        .done  (tmr_done)
    );

    lsup_sat_count #(.W(RETRY_W)) u_retries (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .clr     (rc_clr),
        .inc     (rc_inc),
        .count_o (retry_cnt)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        ctl_d.hold  = usr_rst | ~good;
        tmr_load    = 1'b0;
        rc_clr      = 1'b0;
        rc_inc      = 1'b0;
        retry       = 1'b0;

        if (!auto_en) begin
            // pass-through only
            ctl_d.st    = SV_OFF;
            ctl_d.pulse = usr_rst;
            if (usr_rst) begin
                ctl_d.sticky = 1'b0;
                rc_clr       = 1'b1;
            end
        end else if (usr_rst) begin
            // user reset wins over any automatic action this cycle
            ctl_d.st     = SV_SETTLE;
            ctl_d.pulse  = 1'b1;
            ctl_d.sticky = 1'b0;
            rc_clr       = 1'b1;
            tmr_load     = 1'b1;
        end else begin
            case (ctl_q.st)
                SV_OFF:    ctl_d.st = SV_PROBE;
                SV_PROBE:  if (good) ctl_d.st = SV_WATCH; else retry = 1'b1;
                SV_WATCH:  if (!good) retry = 1'b1;
                SV_PULSE: begin
                    ctl_d.st = SV_SETTLE;
                    tmr_load = 1'b1;
                end
                SV_SETTLE: if (tmr_done) ctl_d.st = SV_PROBE;
                default:   ctl_d.st = SV_OFF;
            endcase
            if (retry) begin
                ctl_d.st     = SV_PULSE;
                ctl_d.pulse  = 1'b1;
                ctl_d.sticky = 1'b1;
                rc_inc       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st     <= SV_OFF;
            ctl_q.pulse  <= 1'b0;
            ctl_q.hold   <= 1'b1;
            ctl_q.sticky <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign synth_rst   = ctl_q.pulse;
    assign hold_rst    = ctl_q.hold;
    assign relock_seen = ctl_q.sticky;
endmodule

// File: rtl/lock_supervisor_chk.sv
module lock_supervisor_chk #(
    parameter int RETRY_W = 4
) (
    input logic               clk_ref,
    input logic               rst_n,
    input logic               auto_en,
    input logic               usr_rst,
    input logic               lock_raw,
    input logic               synth_rst,
    input logic               hold_rst,
    input logic               relock_seen,
    input logic [RETRY_W-1:0] retry_cnt
);
    localparam logic [RETRY_W-1:0] MAXV = '1;

    p_one_cycle_pulse_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (synth_rst && auto_en && !usr_rst && $past(auto_en) && !$past(usr_rst)) |=> !synth_rst);

    p_passthrough_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !auto_en |=> (synth_rst == $past(usr_rst)));

    p_off_no_set_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !auto_en |=> !$rose(relock_seen));

    p_sticky_keeps_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (relock_seen && !usr_rst) |=> relock_seen);

    p_saturate_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (retry_cnt == MAXV && !usr_rst) |=> (retry_cnt == MAXV));

    p_user_priority_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        usr_rst |=> (synth_rst && hold_rst && !relock_seen && retry_cnt == '0));

    p_nolock_holds_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !lock_raw |-> ##3 hold_rst);
endmodule

bind lock_supervisor lock_supervisor_chk #(.RETRY_W(RETRY_W)) u_chk (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .auto_en     (auto_en),
    .usr_rst     (usr_rst),
    .lock_raw    (lock_raw),
    .synth_rst   (synth_rst),
    .hold_rst    (hold_rst),
    .relock_seen (relock_seen),
    .retry_cnt   (retry_cnt)
);

// File: tb/lock_supervisor_test.sv
`timescale 1ns/1ps
module lock_supervisor_test;
    localparam int CPU = 3;
    localparam int WU  = 2;
    localparam int S   = CPU * WU;
    localparam int RW  = 3;
    localparam int RMAX = (1 << RW) - 1;

    logic clk = 1'b0;
    logic rst_n, auto_en, usr_rst, fx_mode, lock_in, in_stop, fx_stop;
    logic synth_rst, hold_rst, relock_seen;
    logic [RW-1:0] retry_cnt;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    lock_supervisor #(.CYC_PER_US(CPU), .WAIT_US(WU), .RETRY_W(RW)) uut (
        .clk_ref(clk), .rst_n(rst_n), .auto_en(auto_en), .usr_rst(usr_rst),
        .fx_mode(fx_mode), .lock_raw(lock_in), .inclk_stop_raw(in_stop),
        .fxclk_stop_raw(fx_stop), .synth_rst(synth_rst), .hold_rst(hold_rst),
        .relock_seen(relock_seen), .retry_cnt(retry_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            tick(1);
            n++;
        end while (!synth_rst && n < 200);
    endtask

    // behavioural cycle model: 0 off, 1 pulse, 2 settle, 3 probe, 4 watch
    int m_st, m_left, m_retry;
    logic [2:0] m_s1, m_s2;
    bit m_pulse, m_hold, m_sticky;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_retry = 0; m_s1 = 0; m_s2 = 0;
            m_pulse = 0; m_hold = 1; m_sticky = 0;
        end else begin
            bit ok, fire;
            ok = m_s2[2] && !m_s2[1] && !(fx_mode && m_s2[0]);
            fire = 0;
            m_hold = usr_rst || !ok;
            m_pulse = 0;
            if (!auto_en) begin
                m_st = 0;
                m_pulse = usr_rst;
                if (usr_rst) begin m_sticky = 0; m_retry = 0; end
            end else if (usr_rst) begin
                m_st = 2; m_left = S - 1; m_pulse = 1; m_sticky = 0; m_retry = 0;
            end else begin
                case (m_st)
                    0: m_st = 3;
                    3: if (ok) m_st = 4; else fire = 1;
                    4: if (!ok) fire = 1;
                    1: begin m_st = 2; m_left = S - 1; end
                    default: if (m_left == 0) m_st = 3; else m_left--;
                endcase
                if (fire) begin
                    m_st = 1; m_pulse = 1; m_sticky = 1;
                    if (m_retry < RMAX) m_retry++;
                end
            end
            m_s2 = m_s1;
            m_s1 = {lock_in, in_stop, fx_stop};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 model synth_rst", int'(synth_rst), int'(m_pulse));
            chk("R9 model hold_rst", int'(hold_rst), int'(m_hold));
            chk("R7 model relock_seen", int'(relock_seen), int'(m_sticky));
            chk("R8 model retry_cnt", int'(retry_cnt), m_retry);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        int n;
        int injected;
        injected = 0;
        rst_n = 0; auto_en = 0; usr_rst = 0; fx_mode = 0;
        lock_in = 0; in_stop = 0; fx_stop = 0;
        tick(3);
        rst_n = 1;
        tick(1);
        chk("R9 hold after reset", int'(hold_rst), 1);
        chk("R3 no pulse after reset", int'(synth_rst), 0);
        chk("R7 sticky clear after reset", int'(relock_seen), 0);
        chk("R8 count zero after reset", int'(retry_cnt), 0);

        // R2 pass-through while disabled
        usr_rst = 1; tick(1);
        chk("R2 user reset forwarded", int'(synth_rst), 1);
        usr_rst = 0; tick(1);
        chk("R2 forward released", int'(synth_rst), 0);
        tick(40);
        chk("R2 no retries while off", int'(retry_cnt), 0);
        chk("R2 sticky untouched while off", int'(relock_seen), 0);

        // R1 synchronizer latency on hold
        lock_in = 1; tick(2);
        chk("R1 hold still high after two edges", int'(hold_rst), 1);
        tick(1);
        chk("R1 hold low after three edges", int'(hold_rst), 0);
        lock_in = 0; tick(3);
        chk("R1 hold back high", int'(hold_rst), 1);

        // R3/R4 periodic retries
        auto_en = 1;
        wait_pulse(n); injected++;
        chk("R3 first retry two cycles after enable", n, 2);
        tick(1);
        chk("R3 pulse lasts one cycle", int'(synth_rst), 0);
        wait_pulse(n); injected++;
        chk("R4 retry spacing", n + 1, S + 2);
        chk("R8 count matches injected failures", int'(retry_cnt), injected);
        chk("R7 sticky set by retry", int'(relock_seen), 1);
        lock_in = 1; tick(S + 6);
        chk("R8 count stops once locked", int'(retry_cnt), injected);
        chk("R9 hold released when locked", int'(hold_rst), 0);

        // R11 loss of lock
        lock_in = 0; tick(3); injected++;
        chk("R11 retry after lock loss", int'(synth_rst), 1);
        lock_in = 1; tick(S + 6);
        chk("R11 count after lock loss", int'(retry_cnt), injected);

        // R5 input clock stopped
        in_stop = 1; tick(3); injected++;
        chk("R5 input stop triggers retry", int'(synth_rst), 1);
        in_stop = 0; tick(S + 6);
        chk("R5 count", int'(retry_cnt), injected);

        // R6 synthesized clock stop depends on mode
        fx_stop = 1; tick(S + 10);
        chk("R6 ignored in mode 0 count", int'(retry_cnt), injected);
        chk("R6 ignored in mode 0 hold", int'(hold_rst), 0);
        fx_mode = 1; tick(1); injected++;
        chk("R6 checked in mode 1", int'(synth_rst), 1);
        fx_stop = 0; tick(S + 6);
        chk("R6 count", int'(retry_cnt), injected);

        // R8 saturation
        lock_in = 0; tick(12 * (S + 2));
        chk("R8 saturates", int'(retry_cnt), RMAX);

        // R10 user reset coincides with an automatic retry
        wait_pulse(n);
        tick(S + 1);
        usr_rst = 1; tick(1);
        chk("R10 reset pulse present", int'(synth_rst), 1);
        chk("R10 count cleared", int'(retry_cnt), 0);
        chk("R10 sticky cleared", int'(relock_seen), 0);
        usr_rst = 0;
        wait_pulse(n);
        chk("R10 settle after user reset", n, S + 1);
        chk("R10 count after first new retry", int'(retry_cnt), 1);

        // R7 sticky across disable, cleared by user reset
        auto_en = 0; tick(30);
        chk("R7 sticky survives disable", int'(relock_seen), 1);
        chk("R2 quiet while disabled", int'(synth_rst), 0);
        usr_rst = 1; tick(1);
        usr_rst = 0; tick(1);
        chk("R7 sticky cleared by user reset", int'(relock_seen), 0);
        finish_run();
    end
endmodule